// File: doc/BRIEF.md
# Gather/Scatter Element Micro-op Expander

This block sits after instruction decode in a vector pipeline. It takes one decoded gather load or scatter store and turns it into a stream of micro-ops. Each micro-op is one of three kinds: a per-element memory access, a leading copy of the address vector, or a trailing fault writeback. Requests arrive over a valid/ready handshake. The block works on one request at a time and emits its micro-ops over a second valid/ready handshake. It does not generate addresses and does not touch memory. It only works out how many micro-ops a request needs and which flags, element indices and address-register choices each one carries.

The number of elements comes from the vector length field and the register element size. A gather first copies its address vector into an auxiliary register, so that a destination register which aliases the address register cannot corrupt later addresses. Its element micro-ops then read from that auxiliary register. A scatter reads the named vector register directly. A first-fault load gets one extra writeback micro-op after its elements. A first-fault request on a store is illegal: the block refuses it, raises an error pulse and emits nothing.

Top module: `gsx_expander`

## Requirements
- R1: The element count is ((in_len + 1) * 16) >> in_esize, where in_esize 0, 1, 2 and 3 select 1, 2, 4 and 8 byte elements. Every micro-op of a request shows this count on out_cnt.
- R2: A load (gather) starts with one copy micro-op (out_kind = 1) flagged first, with out_aux = 0 and out_vreg = in_vreg. All of its element micro-ops have out_aux = 1.
- R3: A store (scatter) emits no copy micro-op. Its element micro-ops have out_aux = 0, and out_vreg equals in_vreg on every micro-op of both request types.
- R4: Element micro-ops (out_kind = 0) appear in ascending index order 0 to count-1. Each carries out_ff, out_dest and out_pred copied from the request.
- R5: A first-fault load ends with one writeback micro-op (out_kind = 2), which comes after every element micro-op.
- R6: A request with in_ff = 1 and in_is_load = 0 is refused. err_ff_store is high for exactly the one cycle after acceptance, and no micro-op is emitted.
- R7: A request produces count + 1 (if it is a load) + 1 (if it is first-fault) micro-ops.
- R8: Only the first micro-op has out_first set and only the final one has out_last set. out_dcommit is set on every micro-op except the final one.
- R9: With in_form = 0 (vector base plus immediate), out_imm = in_imm << in_msize and out_mods = 0. With in_form = 1 (scalar base plus vector offset), out_mods = in_mods and out_imm = 0.
- R10: in_ready is high only while no request is in progress. While out_valid is high and out_ready is low, the micro-op fields hold steady. in_ready returns the cycle after the final transfer.
- R11: After reset, in_ready = 1, out_valid = 0 and err_ff_store = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block can accept a request |
| in_is_load | input | 1 | 1 = gather load, 0 = scatter store |
| in_len | input | LEN_W | Vector length field |
| in_esize | input | 2 | log2 of the register element size in bytes |
| in_msize | input | 2 | log2 of the memory element size in bytes |
| in_form | input | 1 | Address form: 0 = vector plus immediate, 1 = scalar plus vector |
| in_mods | input | 3 | Offset modifiers: bit 0 = 32-bit offset, bit 1 = signed, bit 2 = scaled |
| in_imm | input | IMM_W | Unscaled immediate |
| in_dest | input | RW | Destination or data vector register |
| in_pred | input | PW | Governing predicate register |
| in_vreg | input | RW | Vector register that supplies addresses |
| in_ff | input | 1 | First-fault request |
| out_valid | output | 1 | Micro-op valid |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_kind | output | 2 | 0 element, 1 copy, 2 fault writeback |
| out_idx | output | CW | Element index (element micro-ops only) |
| out_cnt | output | CW | Element count of the request |
| out_vreg | output | RW | Original address vector register |
| out_aux | output | 1 | Element reads addresses from the auxiliary register |
| out_ff | output | 1 | First-fault flag |
| out_first | output | 1 | First micro-op of the request |
| out_last | output | 1 | Final micro-op of the request |
| out_dcommit | output | 1 | Delayed-commit flag |
| out_dest | output | RW | Destination register |
| out_pred | output | PW | Predicate register |
| out_form | output | 1 | Address form |
| out_mods | output | 3 | Offset modifiers (scalar plus vector form) |
| out_imm | output | IMM_W+3 | Scaled immediate (vector plus immediate form) |
| err_ff_store | output | 1 | One-cycle pulse for a refused first-fault store |

## Verification
The hardest case to reach is a first-fault gather at the largest length with byte elements. In that case the copy, the 256 element operations and the writeback all fall in one 258-long stream, and the final index and the writeback both sit next to the last flag. The bench sweeps every length field against every element size and every load/first-fault combination. That sweep covers both this extreme and the two-element minimum. The consumer stalls on a rotating pattern, so hold behaviour is tested on copy, element and writeback micro-ops alike.

// File: rtl/gsx_pkg.sv
package gsx_pkg;
  typedef enum logic [1:0] {
    UK_ELEM = 2'd0,
    UK_COPY = 2'd1,
    UK_FFWB = 2'd2
  } uop_kind_e;

  localparam int unsigned CHUNK_BYTES = 16;
  localparam int unsigned CHUNK_SH    = 4;
endpackage

// File: rtl/gsx_count.sv
module gsx_count
  import gsx_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int CW    = 9
) (
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       esize,
  input  logic             gather,
  input  logic             ff,
  output logic [CW-1:0]    elem_cnt,
  output logic [CW-1:0]    total_cnt
);
  logic [CW-1:0] bytes;

  always_comb begin
    bytes     = (CW'(len) + CW'(1)) << CHUNK_SH;
    elem_cnt  = bytes >> esize;
    total_cnt = elem_cnt + CW'(gather) + CW'(ff);
  end
endmodule

// File: rtl/gsx_seq.sv
module gsx_seq #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] total_in,
  input  logic          adv,
  output logic          busy,
  output logic [CW-1:0] pos,
  output logic          at_last
);
  logic          busy_q, busy_d;
  logic [CW-1:0] pos_q, pos_d;
  logic [CW-1:0] tot_q, tot_d;
  logic          en;

  assign at_last = busy_q && (pos_q == tot_q - CW'(1));

  always_comb begin
    busy_d = busy_q;
    pos_d  = pos_q;
    tot_d  = tot_q;
    en     = 1'b0;
    if (start) begin
      en     = 1'b1;
      busy_d = 1'b1;
      pos_d  = '0;
      tot_d  = total_in;
    end else if (busy_q && adv) begin
      en = 1'b1;
      if (at_last) begin
        busy_d = 1'b0;
        pos_d  = '0;
      end else begin
        pos_d = pos_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      tot_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      pos_q  <= pos_d;
      tot_q  <= tot_d;
    end
  end

  assign busy = busy_q;
  assign pos  = pos_q;

  // R10
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !adv && !start |=> busy_q && $stable(pos_q));

  // R7
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> pos_q < tot_q);
endmodule

// File: rtl/gsx_fmt.sv
module gsx_fmt
  import gsx_pkg::*;
#(
  parameter int CW = 9
) (
  input  logic [CW-1:0] pos,
  input  logic          at_last,
  input  logic          gather,
  input  logic          ff,
  output uop_kind_e     kind,
  output logic [CW-1:0] idx,
  output logic          aux,
  output logic          first,
  output logic          dcommit
);
  always_comb begin
    kind = UK_ELEM;
    idx  = pos - CW'(gather);
    if (gather && pos == '0) begin
      kind = UK_COPY;
      idx  = '0;
    end else if (ff && at_last) begin
      kind = UK_FFWB;
      idx  = '0;
    end
    aux     = gather && (kind == UK_ELEM);
    first   = (pos == '0);
    dcommit = !at_last;
  end
endmodule

// File: rtl/gsx_expander.sv
module gsx_expander
  import gsx_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int IMM_W = 5,
  parameter int RW    = 5,
  parameter int PW    = 4,
  localparam int CW   = $clog2(((1 << LEN_W) * CHUNK_BYTES) + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_is_load,
  input  logic [LEN_W-1:0] in_len,
  input  logic [1:0]       in_esize,
  input  logic [1:0]       in_msize,
  input  logic             in_form,
  input  logic [2:0]       in_mods,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [RW-1:0]    in_dest,
  input  logic [PW-1:0]    in_pred,
  input  logic [RW-1:0]    in_vreg,
  input  logic             in_ff,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_kind,
  output logic [CW-1:0]    out_idx,
  output logic [CW-1:0]    out_cnt,
  output logic [RW-1:0]    out_vreg,
  output logic             out_aux,
  output logic             out_ff,
  output logic             out_first,
  output logic             out_last,
  output logic             out_dcommit,
  output logic [RW-1:0]    out_dest,
  output logic [PW-1:0]    out_pred,
  output logic             out_form,
  output logic [2:0]       out_mods,
  output logic [IMM_W+2:0] out_imm,
  output logic             err_ff_store
);
  localparam int SIMM_W = IMM_W + 3;

  logic          accept, illegal, start;
  logic [CW-1:0] ecnt_c, total_c;
  logic          busy, at_last;
  logic [CW-1:0] pos;
  uop_kind_e     kind;

  // request register fields
  logic              ld_q;
  logic              ff_q;
  logic              form_q;
  logic [2:0]        mods_q;
  logic [SIMM_W-1:0] imm_q;
  logic [RW-1:0]     dest_q, vreg_q;
  logic [PW-1:0]     pred_q;
  logic [CW-1:0]     ecnt_q;
  logic              err_q, err_d;

  logic [SIMM_W-1:0] imm_scaled;
  logic [2:0]        mods_sel;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign illegal  = in_ff && !in_is_load;
  assign start    = accept && !illegal;

  gsx_count #(.LEN_W(LEN_W), .CW(CW)) u_count (
    .len       (in_len),
    .esize     (in_esize),
    .gather    (in_is_load),
    .ff        (in_ff),
    .elem_cnt  (ecnt_c),
    .total_cnt (total_c)
  );

  gsx_seq #(.CW(CW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .total_in (total_c),
    .adv      (out_ready),
    .busy     (busy),
    .pos      (pos),
    .at_last  (at_last)
  );

  gsx_fmt #(.CW(CW)) u_fmt (
    .pos     (pos),
    .at_last (at_last),
    .gather  (ld_q),
    .ff      (ff_q),
    .kind    (kind),
    .idx     (out_idx),
    .aux     (out_aux),
    .first   (out_first),
    .dcommit (out_dcommit)
  );

  always_comb begin
    imm_scaled = in_form ? '0 : (SIMM_W'(in_imm) << in_msize);
    mods_sel   = in_form ? in_mods : 3'b000;
    err_d      = accept && illegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q   <= 1'b0;
      ff_q   <= 1'b0;
      form_q <= 1'b0;
      mods_q <= '0;
      imm_q  <= '0;
      dest_q <= '0;
      vreg_q <= '0;
      pred_q <= '0;
      ecnt_q <= '0;
    end else if (start) begin
      ld_q   <= in_is_load;
      ff_q   <= in_ff;
      form_q <= in_form;
      mods_q <= mods_sel;
      imm_q  <= imm_scaled;
      dest_q <= in_dest;
      vreg_q <= in_vreg;
      pred_q <= in_pred;
      ecnt_q <= ecnt_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign out_valid    = busy;
  assign out_kind     = kind;
  assign out_cnt      = ecnt_q;
  assign out_vreg     = vreg_q;
  assign out_ff       = ff_q;
  assign out_last     = at_last;
  assign out_dest     = dest_q;
  assign out_pred     = pred_q;
  assign out_form     = form_q;
  assign out_mods     = mods_q;
  assign out_imm      = imm_q;
  assign err_ff_store = err_q;

  // R8
  start_is_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_first);

  // R2
  copy_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd1 |-> out_first && !out_aux);

  // R5
  wb_trails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd2 |-> out_last && out_ff);

  // R6
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ff_store |-> !out_valid && in_ready);

  // R10
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last && out_kind == 2'd0
    |=> out_kind != 2'd0 || out_idx == $past(out_idx) + CW'(1));

  // R8
  seq_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && !out_first);
endmodule

// File: tb/tb_gsx_expander.sv
module tb_gsx_expander;
  localparam int LEN_W = 4;
  localparam int IMM_W = 5;
  localparam int RW    = 5;
  localparam int PW    = 4;
  localparam int CW    = 9;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid, in_ready, in_is_load, in_form, in_ff;
  logic [LEN_W-1:0] in_len;
  logic [1:0]       in_esize, in_msize;
  logic [2:0]       in_mods;
  logic [IMM_W-1:0] in_imm;
  logic [RW-1:0]    in_dest, in_vreg;
  logic [PW-1:0]    in_pred;
  logic             out_valid, out_ready, out_aux, out_ff, out_first, out_last;
  logic             out_dcommit, out_form, err_ff_store;
  logic [1:0]       out_kind;
  logic [CW-1:0]    out_idx, out_cnt;
  logic [RW-1:0]    out_vreg, out_dest;
  logic [PW-1:0]    out_pred;
  logic [2:0]       out_mods;
  logic [IMM_W+2:0] out_imm;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gsx_expander dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_load(in_is_load), .in_len(in_len), .in_esize(in_esize),
    .in_msize(in_msize), .in_form(in_form), .in_mods(in_mods),
    .in_imm(in_imm), .in_dest(in_dest), .in_pred(in_pred),
    .in_vreg(in_vreg), .in_ff(in_ff), .out_valid(out_valid),
    .out_ready(out_ready), .out_kind(out_kind), .out_idx(out_idx),
    .out_cnt(out_cnt), .out_vreg(out_vreg), .out_aux(out_aux),
    .out_ff(out_ff), .out_first(out_first), .out_last(out_last),
    .out_dcommit(out_dcommit), .out_dest(out_dest), .out_pred(out_pred),
    .out_form(out_form), .out_mods(out_mods), .out_imm(out_imm),
    .err_ff_store(err_ff_store)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_one(input int ld, input int ff, input int len,
                         input int es, input int n);
    int ecnt, tot, g, form, mods, imm, ms, dest, pred, vreg;
    int kind_e, idx_e, snap_k, snap_i;
    g    = ld;
    ecnt = ((len + 1) * 16) >> es;
    tot  = ecnt + g + ff;
    form = (len + es) % 2;
    mods = (len * 3 + es) % 8;
    imm  = (len * 5 + es * 7) % 32;
    ms   = len % (es + 1);
    dest = (len * 2 + es) % 32;
    pred = (len + es * 3) % 16;
    vreg = (len % 2 == 1) ? dest : (dest + 1) % 32;

    in_valid   = 1'b1;
    in_is_load = ld[0];
    in_ff      = ff[0];
    in_len     = LEN_W'(len);
    in_esize   = 2'(es);
    in_msize   = 2'(ms);
    in_form    = form[0];
    in_mods    = 3'(mods);
    in_imm     = IMM_W'(imm);
    in_dest    = RW'(dest);
    in_pred    = PW'(pred);
    in_vreg    = RW'(vreg);
    @(negedge clk);
    in_valid = 1'b0;

    if (ff == 1 && ld == 0) begin
      chk("R6 err pulse", int'(err_ff_store), 1);
      chk("R6 no micro-op", int'(out_valid), 0);
      @(negedge clk);
      chk("R6 err one cycle", int'(err_ff_store), 0);
      chk("R6 still idle", int'(out_valid), 0);
      return;
    end

    for (int p = 0; p < tot; p++) begin
      if (p == 0) kind_e = g ? 1 : 0;
      else if (ff == 1 && p == tot - 1) kind_e = 2;
      else kind_e = 0;
      idx_e = (kind_e == 0) ? p - g : 0;
      if ((p + n) % 3 == 1) begin
        out_ready = 1'b0;
        snap_k = int'(out_kind);
        snap_i = int'(out_idx);
        @(negedge clk);
        chk("R10 hold valid", int'(out_valid), 1);
        chk("R10 hold kind", int'(out_kind), snap_k);
        chk("R10 hold idx", int'(out_idx), snap_i);
        chk("R10 in_ready low", int'(in_ready), 0);
      end
      out_ready = 1'b1;
      chk("R7 valid", int'(out_valid), 1);
      chk("R1 count", int'(out_cnt), ecnt);
      chk(g ? "R2 kind" : "R3 kind", int'(out_kind), kind_e);
      chk("R4 idx", int'(out_idx), idx_e);
      chk(g ? "R2 aux" : "R3 aux", int'(out_aux), (g == 1 && kind_e == 0) ? 1 : 0);
      chk("R3 vreg", int'(out_vreg), vreg);
      chk("R4 ff", int'(out_ff), ff);
      chk("R4 dest", int'(out_dest), dest);
      chk("R4 pred", int'(out_pred), pred);
      chk("R8 first", int'(out_first), (p == 0) ? 1 : 0);
      chk("R8 last", int'(out_last), (p == tot - 1) ? 1 : 0);
      chk("R8 dcommit", int'(out_dcommit), (p == tot - 1) ? 0 : 1);
      chk("R9 imm", int'(out_imm), form ? 0 : (imm << ms));
      chk("R9 mods", int'(out_mods), form ? mods : 0);
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk("R7 stream ends", int'(out_valid), 0);
    chk("R10 ready returns", int'(in_ready), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired actual 0 expected 1");
    checks++;
    errors++;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0;
    in_valid = 1'b0; in_is_load = 1'b0; in_ff = 1'b0; in_len = '0;
    in_esize = '0; in_msize = '0; in_form = 1'b0; in_mods = '0;
    in_imm = '0; in_dest = '0; in_pred = '0; in_vreg = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset ready", int'(in_ready), 1);
    chk("R11 reset valid", int'(out_valid), 0);
    chk("R11 reset err", int'(err_ff_store), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after release ready", int'(in_ready), 1);
    chk("R11 after release valid", int'(out_valid), 0);
    n = 0;
    for (int mode = 0; mode < 4; mode++) begin
      for (int len = 0; len < 16; len++) begin
        for (int es = 0; es < 4; es++) begin
          run_one(mode % 2, mode / 2, len, es, n);
          n++;
        end
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule